// File: doc/BRIEF.md
# Segment Relocation and Bounds Check Unit

This block sits between a processor's load/store path and memory. Each access presents a virtual offset, a segment number and the current privilege level. The block looks up the base and the limit of the chosen segment and adds the base to the offset to form the physical address. If the offset is not below the limit, it raises a fault instead, so the access never reaches memory. The physical address and the fault flag are registered and appear one cycle after the request, together with a response-valid strobe.

The supervisor owns the segment registers. A write to a base or limit register takes effect only while the privilege input says kernel mode. A write attempted in user mode changes nothing and is reported on a one-cycle flag. On a context switch the supervisor rewrites the pairs. A program then runs from a different region of physical memory and keeps the same virtual offsets. The block also keeps the virtual address of the most recent faulting access so that software can inspect it later.

Top module: `seg_xlate_unit`

## Requirements
- R1: After reset, rsp_valid, rsp_fault, cfg_denied, rsp_paddr and fault_vaddr are all 0. Every segment has base 0 and limit 0, so any access faults until the segment is programmed.
- R2: For an accepted request whose offset is below the selected limit, the cycle after the request shows rsp_valid=1, rsp_fault=0 and rsp_paddr = base + offset, taken modulo 2^ADDR_W.
- R3: The limit test is unsigned, and an offset equal to or above the limit is out of range. Such a request gives rsp_valid=1, rsp_fault=1 and rsp_paddr=0 one cycle later.
- R4: A write with cfg_wr_en=1 and priv_kernel=1 loads cfg_wdata into segment cfg_seg. cfg_field=0 selects the base and cfg_field=1 selects the limit. The new value applies to requests issued from the next cycle on.
- R5: A write with cfg_wr_en=1 and priv_kernel=0 leaves every register unchanged and drives cfg_denied=1 for one cycle, starting the cycle after the attempt. At all other times cfg_denied is 0.
- R6: Each request uses only the base/limit pair of the segment named by req_seg, and programming one segment does not change how another one translates.
- R7: On a faulting request, fault_vaddr takes that request's virtual address in the same cycle that rsp_fault is shown. fault_vaddr then holds until the next fault.
- R8: In a cycle after no request, rsp_valid=0, rsp_fault=0 and rsp_paddr=0.
- R9: Rewriting a segment's base relocates the program: the same offsets then map into the new region. With base 0x20000 and limit 0x10000, offsets 0x0..0xFFFF map to 0x20000..0x2FFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request strobe |
| req_seg | input | SEL_W | Segment number of the access |
| req_vaddr | input | ADDR_W | Virtual offset within the segment |
| priv_kernel | input | 1 | 1 = kernel mode, 0 = user mode |
| cfg_wr_en | input | 1 | Segment register write strobe |
| cfg_seg | input | SEL_W | Segment whose register is written |
| cfg_field | input | 1 | 0 = base, 1 = limit |
| cfg_wdata | input | ADDR_W | Value to write |
| rsp_valid | output | 1 | Response strobe, one cycle after req_valid |
| rsp_paddr | output | ADDR_W | Physical address, 0 on fault or idle |
| rsp_fault | output | 1 | Bounds violation for the request |
| cfg_denied | output | 1 | One-cycle flag for a rejected user-mode write |
| fault_vaddr | output | ADDR_W | Virtual address of the latest faulting access |

## Verification
Every translation result (rsp_valid, rsp_paddr, rsp_fault) and each update of fault_vaddr is due exactly one clock edge after the request. cfg_denied is due one edge after the write attempt. A register write becomes visible to requests that are launched after the edge that stores it. The bench changes inputs on the falling edge and samples outputs on the next falling edge, so every sample lands half a period after the single edge that produces the result. Each write is completed before the request that is meant to see it is driven.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  localparam int unsigned DEF_ADDR_W  = 32;
  localparam int unsigned DEF_SEG_CNT = 4;

  // Which half of a segment pair a configuration write targets
  typedef enum logic {
    FLD_BASE  = 1'b0,
    FLD_LIMIT = 1'b1
  } seg_field_e;
endpackage

// File: rtl/seg_priv_guard.sv
module seg_priv_guard (
  input  logic clk,
  input  logic rst,
  input  logic cfg_wr_en,
  input  logic priv_kernel,
  output logic wr_allow,
  output logic denied_q
);
  // Only kernel-mode writes reach the register bank
  assign wr_allow = cfg_wr_en & priv_kernel;

  always_ff @(posedge clk) begin
    if (rst) denied_q <= 1'b0;
    else     denied_q <= cfg_wr_en & ~priv_kernel;
  end
endmodule

// File: rtl/seg_bank.sv
module seg_bank
  import seg_xlate_pkg::*;
#(
  parameter int unsigned ADDR_W  = DEF_ADDR_W,
  parameter int unsigned SEG_CNT = DEF_SEG_CNT,
  parameter int unsigned SEL_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_allow,
  input  logic [SEL_W-1:0]  wr_seg,
  input  seg_field_e        wr_field,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic [SEL_W-1:0]  rd_seg,
  output logic [ADDR_W-1:0] rd_base,
  output logic [ADDR_W-1:0] rd_limit
);
  logic [ADDR_W-1:0] base_q  [SEG_CNT];
  logic [ADDR_W-1:0] limit_q [SEG_CNT];

  for (genvar g = 0; g < SEG_CNT; g++) begin : g_seg
    localparam logic [SEL_W-1:0] ID = SEL_W'(g);
    wire hit = wr_allow && (wr_seg == ID);

    always_ff @(posedge clk) begin
      if (rst) begin
        base_q[g]  <= '0;
        limit_q[g] <= '0;
      end else if (hit) begin
        if (wr_field == FLD_BASE) base_q[g]  <= wr_data;
        else                      limit_q[g] <= wr_data;
      end
    end
  end

  // Small bank: plain mux read so the pair is available in the request cycle
  always_comb begin
    rd_base  = '0;
    rd_limit = '0;
    for (int i = 0; i < SEG_CNT; i++) begin
      if (rd_seg == SEL_W'(i)) begin
        rd_base  = base_q[i];
        rd_limit = limit_q[i];
      end
    end
  end
endmodule

// File: rtl/seg_check.sv
module seg_check #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] offset,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] limit,
  output logic [ADDR_W-1:0] paddr,
  output logic              out_of_range
);
  // Unsigned bound: offset equal to the limit is already outside
  assign out_of_range = (offset >= limit);
  assign paddr        = offset + base;
endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
  import seg_xlate_pkg::*;
#(
  parameter  int unsigned ADDR_W  = DEF_ADDR_W,
  parameter  int unsigned SEG_CNT = DEF_SEG_CNT,
  localparam int unsigned SEL_W   = (SEG_CNT > 1) ? $clog2(SEG_CNT) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [SEL_W-1:0]  req_seg,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic              priv_kernel,
  input  logic              cfg_wr_en,
  input  logic [SEL_W-1:0]  cfg_seg,
  input  logic              cfg_field,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic              rsp_fault,
  output logic              cfg_denied,
  output logic [ADDR_W-1:0] fault_vaddr
);
  logic              wr_allow;
  logic [ADDR_W-1:0] sel_base, sel_limit, sum_addr;
  logic              oob;

  seg_priv_guard u_guard (
    .clk         (clk),
    .rst         (rst),
    .cfg_wr_en   (cfg_wr_en),
    .priv_kernel (priv_kernel),
    .wr_allow    (wr_allow),
    .denied_q    (cfg_denied)
  );

  seg_bank #(.ADDR_W(ADDR_W), .SEG_CNT(SEG_CNT), .SEL_W(SEL_W)) u_bank (
    .clk      (clk),
    .rst      (rst),
    .wr_allow (wr_allow),
    .wr_seg   (cfg_seg),
    .wr_field (seg_field_e'(cfg_field)),
    .wr_data  (cfg_wdata),
    .rd_seg   (req_seg),
    .rd_base  (sel_base),
    .rd_limit (sel_limit)
  );

  seg_check #(.ADDR_W(ADDR_W)) u_check (
    .offset       (req_vaddr),
    .base         (sel_base),
    .limit        (sel_limit),
    .paddr        (sum_addr),
    .out_of_range (oob)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid   <= 1'b0;
      rsp_fault   <= 1'b0;
      rsp_paddr   <= '0;
      fault_vaddr <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_fault <= req_valid & oob;
      rsp_paddr <= (req_valid && !oob) ? sum_addr : '0;
      if (req_valid && oob) fault_vaddr <= req_vaddr;
    end
  end
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_vaddr,
  input logic              cfg_wr_en,
  input logic              priv_kernel,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] rsp_paddr,
  input logic              rsp_fault,
  input logic              cfg_denied,
  input logic [ADDR_W-1:0] fault_vaddr
);
  AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid); // R2
  AST_NO_RSP_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> (!rsp_fault && rsp_paddr == '0)); // R8
  AST_FAULT_ZERO_ADDR: assert property (@(posedge clk) disable iff (rst)
    rsp_fault |-> (rsp_valid && rsp_paddr == '0)); // R3
  AST_USER_WRITE_DENIED: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr_en && !priv_kernel) |=> cfg_denied); // R5
  AST_DENIED_ONLY_USER: assert property (@(posedge clk) disable iff (rst)
    !(cfg_wr_en && !priv_kernel) |=> !cfg_denied); // R5
  AST_FAULT_ADDR_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (rsp_fault -> fault_vaddr == $past(req_vaddr))); // R7
  AST_FAULT_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rsp_fault |=> (rsp_fault || $stable(fault_vaddr))); // R7
endmodule

bind seg_xlate_unit seg_xlate_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_valid   (req_valid),
  .req_vaddr   (req_vaddr),
  .cfg_wr_en   (cfg_wr_en),
  .priv_kernel (priv_kernel),
  .rsp_valid   (rsp_valid),
  .rsp_paddr   (rsp_paddr),
  .rsp_fault   (rsp_fault),
  .cfg_denied  (cfg_denied),
  .fault_vaddr (fault_vaddr)
);

// File: tb/sim_seg_xlate_unit.sv
module sim_seg_xlate_unit;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int SW = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic [SW-1:0] req_seg = '0;
  logic [AW-1:0] req_vaddr = '0;
  logic          priv_kernel = 1'b0;
  logic          cfg_wr_en = 1'b0;
  logic [SW-1:0] cfg_seg = '0;
  logic          cfg_field = 1'b0;
  logic [AW-1:0] cfg_wdata = '0;
  logic          rsp_valid, rsp_fault, cfg_denied;
  logic [AW-1:0] rsp_paddr, fault_vaddr;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_xlate_unit u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_seg(req_seg),
    .req_vaddr(req_vaddr), .priv_kernel(priv_kernel), .cfg_wr_en(cfg_wr_en),
    .cfg_seg(cfg_seg), .cfg_field(cfg_field), .cfg_wdata(cfg_wdata),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
    .cfg_denied(cfg_denied), .fault_vaddr(fault_vaddr)
  );

  task automatic check(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // Write one register; returns the cfg_denied value seen one edge later
  task automatic cfg_write(input logic kern, input logic [SW-1:0] seg, input logic fld,
                           input logic [AW-1:0] val, output logic denied);
    @(negedge clk);
    priv_kernel = kern; cfg_wr_en = 1'b1; cfg_seg = seg; cfg_field = fld; cfg_wdata = val;
    @(negedge clk);
    denied = cfg_denied;
    cfg_wr_en = 1'b0; priv_kernel = 1'b0;
  endtask

  task automatic access(input logic [SW-1:0] seg, input logic [AW-1:0] va,
                        output logic v, output logic f, output logic [AW-1:0] pa);
    @(negedge clk);
    req_valid = 1'b1; req_seg = seg; req_vaddr = va;
    @(negedge clk);
    v = rsp_valid; f = rsp_fault; pa = rsp_paddr;
    req_valid = 1'b0;
  endtask

  task automatic t_reset();
    logic v, f; logic [AW-1:0] pa;
    check("R1 rsp_valid", {31'b0, rsp_valid}, 0);
    check("R1 rsp_fault", {31'b0, rsp_fault}, 0);
    check("R1 cfg_denied", {31'b0, cfg_denied}, 0);
    check("R1 rsp_paddr", rsp_paddr, 0);
    check("R1 fault_vaddr", fault_vaddr, 0);
    access(2'd1, 32'h0, v, f, pa);
    check("R1 unprogrammed access faults", {31'b0, f}, 1);
    check("R1 fault addr zero", pa, 0);
  endtask

  task automatic t_program();
    logic d, v, f; logic [AW-1:0] pa;
    cfg_write(1'b1, 2'd0, 1'b0, 32'h0002_0000, d);
    check("R4 kernel base write not denied", {31'b0, d}, 0);
    cfg_write(1'b1, 2'd0, 1'b1, 32'h0001_0000, d);
    access(2'd0, 32'h0000_FFFF, v, f, pa);
    check("R2 valid", {31'b0, v}, 1);
    check("R2 no fault", {31'b0, f}, 0);
    check("R9 top offset 0xFFFF", pa, 32'h0002_FFFF);
    access(2'd0, 32'h0, v, f, pa);
    check("R4 offset 0 maps to base", pa, 32'h0002_0000);
    access(2'd0, 32'h0001_0000, v, f, pa);
    check("R3 offset == limit faults", {31'b0, f}, 1);
    check("R3 paddr zero on fault", pa, 0);
    check("R3 valid on fault", {31'b0, v}, 1);
    access(2'd0, 32'hFFFF_FFFF, v, f, pa);
    check("R3 unsigned large offset faults", {31'b0, f}, 1);
  endtask

  task automatic t_segments();
    logic d, v, f; logic [AW-1:0] pa;
    cfg_write(1'b1, 2'd2, 1'b0, 32'h8000_0000, d);
    cfg_write(1'b1, 2'd2, 1'b1, 32'h0000_0100, d);
    access(2'd2, 32'h0000_00FF, v, f, pa);
    check("R6 seg2 translate", pa, 32'h8000_00FF);
    access(2'd2, 32'h0000_0100, v, f, pa);
    check("R6 seg2 own limit", {31'b0, f}, 1);
    access(2'd0, 32'h0000_0100, v, f, pa);
    check("R6 seg0 unaffected", pa, 32'h0002_0100);
    access(2'd3, 32'h0, v, f, pa);
    check("R6 seg3 still unprogrammed", {31'b0, f}, 1);
    cfg_write(1'b1, 2'd1, 1'b0, 32'hFFFF_FFF0, d);
    cfg_write(1'b1, 2'd1, 1'b1, 32'h0000_0100, d);
    access(2'd1, 32'h0000_0020, v, f, pa);
    check("R2 sum wraps modulo width", pa, 32'h0000_0010);
  endtask

  task automatic t_user_write();
    logic d, v, f; logic [AW-1:0] pa;
    cfg_write(1'b0, 2'd0, 1'b0, 32'h0000_5000, d);
    check("R5 user write flagged", {31'b0, d}, 1);
    @(negedge clk);
    check("R5 flag lasts one cycle", {31'b0, cfg_denied}, 0);
    access(2'd0, 32'h0000_0010, v, f, pa);
    check("R5 base unchanged", pa, 32'h0002_0010);
    cfg_write(1'b0, 2'd0, 1'b1, 32'hFFFF_FFFF, d);
    access(2'd0, 32'h0001_0000, v, f, pa);
    check("R5 limit unchanged", {31'b0, f}, 1);
  endtask

  task automatic t_fault_capture();
    logic v, f; logic [AW-1:0] pa;
    access(2'd2, 32'h0001_2345, v, f, pa);
    check("R7 fault flagged", {31'b0, f}, 1);
    check("R7 vaddr captured", fault_vaddr, 32'h0001_2345);
    access(2'd0, 32'h0000_0004, v, f, pa);
    check("R7 held after good access", fault_vaddr, 32'h0001_2345);
  endtask

  task automatic t_idle();
    @(negedge clk);
    @(negedge clk);
    check("R8 idle valid", {31'b0, rsp_valid}, 0);
    check("R8 idle fault", {31'b0, rsp_fault}, 0);
    check("R8 idle paddr", rsp_paddr, 0);
  endtask

  task automatic t_relocate();
    logic d, v, f; logic [AW-1:0] pa;
    cfg_write(1'b1, 2'd0, 1'b0, 32'h0004_0000, d);
    access(2'd0, 32'h0000_0010, v, f, pa);
    check("R9 relocated offset", pa, 32'h0004_0010);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_program();
    t_segments();
    t_user_write();
    t_fault_capture();
    t_idle();
    t_relocate();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule